// File: doc/BRIEF.md
# Compare-Match Waveform Generator

This block turns the value of an external free-running counter into two waveform outputs. Each of the two channels compares the count against its own compare register. Depending on the selected wave mode, a channel either toggles its output on every match, which gives a square wave with a fixed 50% duty cycle, or drives a pulse train. In the pulse-train case the period is set by the counter's top value and the duty cycle by the compare value. The block also works out the top value from the mode and the counter size. It tells the counter when to reload, and it reports a registered match flag for each channel.

The compare and period values can be written directly or through shadow buffers. A buffered value waits with a pending flag until an update condition occurs, which is either the counter's overflow/underflow strobe or an explicit update command. A lock input can hold all pending values back. Each output can be inverted on its own.

Top module: `wavegen_top`

## Requirements
- R1: Wave mode encoding on `mode_i`: 2'b00 normal frequency, 2'b01 match frequency, 2'b10 normal PWM, 2'b11 match PWM. In the PWM modes, the raw channel output goes high on the clock edge after the count is 0 and goes low on the edge after a compare match. If both hold in the same cycle, the match wins.
- R2: In the frequency modes, the raw channel output inverts on the clock edge after each compare match and holds otherwise.
- R3: `match_o[i]` is high for exactly the cycle after the one in which `count_i` equals channel i's active compare value, masked to the counter size.
- R4: Size encoding on `size_i`: 2'b00 8-bit, 2'b01 16-bit, 2'b10/2'b11 32-bit. `top_o` is the active period value for 8-bit. For 16-bit and 32-bit it is the size maximum (0xFFFF or 0xFFFFFFFF) in the normal modes and the active channel 0 compare value in the match modes.
- R5: `reload_o` is combinational. It is high when counting up with `count_i == top_o`, or when counting down with `count_i == 0`, and low otherwise.
- R6: `wave_o[i]` is the raw output XOR `inv_i[i]`. The inversion takes effect without a clock edge, and each channel's bit affects only that channel.
- R7: A compare value above the top never matches while the count stays within 0..top. In PWM mode a non-inverted output then stays high (100% duty).
- R8: With `buf_en_i` high, a write goes to a shadow register and the active value stays unchanged until an update commits it.
- R9: An update occurs on `ovf_i` or `upd_cmd_i` while `upd_lock_i` is low. It copies every pending shadow value into its active register and clears the pending flag. While the lock is high, nothing commits.
- R10: With `buf_en_i` low, a write updates the active register at the clock edge, and the new value is used from the next cycle.
- R11: While `rst_n` is low, the active registers, match flags and raw outputs clear to 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | CNT_W | Current counter value |
| count_down_i | input | 1 | Count direction, 1 = down |
| ovf_i | input | 1 | Overflow/underflow strobe from the counter |
| mode_i | input | 2 | Wave mode select (R1) |
| size_i | input | 2 | Counter size select (R4) |
| inv_i | input | NCH | Per-channel output inversion |
| buf_en_i | input | 1 | Route writes to shadow registers |
| per_wr_i | input | 1 | Period write strobe |
| per_data_i | input | CNT_W | Period write data |
| cc_wr_i | input | NCH | Per-channel compare write strobe |
| cc_data_i | input | CNT_W | Compare write data (shared) |
| upd_cmd_i | input | 1 | Explicit update command |
| upd_lock_i | input | 1 | Blocks commit of pending values |
| wave_o | output | NCH | Waveform outputs |
| match_o | output | NCH | Registered match flags |
| reload_o | output | 1 | Reload request to the counter |
| top_o | output | CNT_W | Current top value |

## Verification
`reload_o`, `top_o` and the effect of `inv_i` are combinational. The bench reads them 1 ns after it drives the inputs, with no clock edge in between. `match_o` and the raw waveform state change one edge after the count is presented, so every count is driven at a falling edge and the result is read 1 ns after the following rising edge. A write or an update command reaches the active registers at the edge where the strobe is sampled. Its effect on a match is therefore checked with a count presented after that edge.

// File: rtl/wg_pkg.sv
// Shared encodings for the waveform generator.
// Assumes: mode and size are held stable by the surrounding logic while running.
package wg_pkg;
    typedef enum logic [1:0] {
        WG_NFRQ = 2'b00,
        WG_MFRQ = 2'b01,
        WG_NPWM = 2'b10,
        WG_MPWM = 2'b11
    } wg_mode_e;

    typedef enum logic [1:0] {
        WG_SZ8   = 2'b00,
        WG_SZ16  = 2'b01,
        WG_SZ32  = 2'b10,
        WG_SZ32B = 2'b11
    } wg_size_e;
endpackage

// File: rtl/wg_shadow.sv
// Double-buffered register: writes go directly to the active value, or to a
// shadow copy with a pending flag that commits on an unlocked update.
// Assumes: wr and upd_req are single-cycle qualified strobes.
module wg_shadow #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buf_en,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         upd_req,
    input  logic         upd_lock,
    output logic [W-1:0] act_o,
    output logic         pend_o
);
    logic [W-1:0] act_q;
    logic [W-1:0] shd_q;
    logic         vld_q;
    logic         commit;

    // Commit happens only when a value is pending and the update is not locked.
    assign commit = upd_req && !upd_lock && vld_q;

    // Active value: a direct write wins, otherwise a commit copies the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (wr && !buf_en)
            act_q <= wdata;
        else if (commit)
            act_q <= shd_q;
    end

    // Shadow copy and pending flag: a buffered write sets, a commit clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q <= '0;
            vld_q <= 1'b0;
        end else if (wr && buf_en) begin
            shd_q <= wdata;
            vld_q <= 1'b1;
        end else if (commit) begin
            vld_q <= 1'b0;
        end
    end

    assign act_o  = act_q;
    assign pend_o = vld_q;

    assert_buffer_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && !buf_en) && !(upd_req && !upd_lock)) |=> $stable(act_q));
    assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_lock && !wr) |=> $stable(act_q));
    assert_commit_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && !upd_lock && vld_q && !wr) |=> !vld_q);
endmodule

// File: rtl/wg_topsel.sv
// Top value selection and reload request.
// Assumes: CNT_W >= 32 so that every size maximum fits.
module wg_topsel
    import wg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  wg_mode_e           mode,
    input  wg_size_e           size,
    input  logic [CNT_W-1:0]   per_act,
    input  logic [CNT_W-1:0]   cc0_act,
    input  logic [CNT_W-1:0]   count,
    input  logic               count_down,
    output logic [CNT_W-1:0]   mask_o,
    output logic [CNT_W-1:0]   top_o,
    output logic               reload_o
);
    localparam logic [CNT_W-1:0] MAX8  = CNT_W'(8'hFF);
    localparam logic [CNT_W-1:0] MAX16 = CNT_W'(16'hFFFF);
    localparam logic [CNT_W-1:0] MAX32 = CNT_W'(32'hFFFF_FFFF);

    logic match_mode;
    assign match_mode = (mode == WG_MFRQ) || (mode == WG_MPWM);

    // Size mask: the largest count the selected size can hold.
    always_comb begin
        case (size)
            WG_SZ8:  mask_o = MAX8;
            WG_SZ16: mask_o = MAX16;
            default: mask_o = MAX32;
        endcase
    end

    // Top: period for 8-bit, else channel 0 in match modes or size maximum.
    always_comb begin
        if (size == WG_SZ8)
            top_o = per_act & MAX8;
        else if (match_mode)
            top_o = cc0_act & mask_o;
        else
            top_o = mask_o;
    end

    // Reload request: up-count reaching top, or down-count reaching zero.
    assign reload_o = count_down ? (count == '0) : (count == top_o);
endmodule

// File: rtl/wg_channel.sv
// One compare channel: registered match flag plus frequency or PWM waveform.
// Assumes: count stays within 0..top; inversion applies after the register.
module wg_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cc,
    input  logic [CNT_W-1:0] mask,
    input  logic             pwm,
    input  logic             inv,
    output logic             wave_o,
    output logic             match_o
);
    logic hit;
    logic at_zero;
    logic match_q;
    logic wave_q;

    assign hit     = (count == (cc & mask));
    assign at_zero = (count == '0);

    // Match flag: registered compare result.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= hit;
    end

    // Raw waveform: PWM set at restart / clear on match, or toggle on match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave_q <= 1'b0;
        else if (pwm) begin
            if (hit)          wave_q <= 1'b0;
            else if (at_zero) wave_q <= 1'b1;
        end else if (hit)
            wave_q <= ~wave_q;
    end

    assign wave_o  = wave_q ^ inv;
    assign match_o = match_q;

    assert_pwm_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && hit) |=> !wave_q);
    assert_pwm_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && at_zero && !hit) |=> wave_q);
    assert_freq_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm && hit) |=> (wave_q != $past(wave_q)));
    assert_match_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !match_q);
endmodule

// File: rtl/wavegen_top.sv
// Compare-match waveform generator: two channels, top selection, reload
// request and double-buffered period/compare values.
// Assumes: an external counter supplies count, direction and overflow strobe.
module wavegen_top
    import wg_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int NCH   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             count_down_i,
    input  logic             ovf_i,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       size_i,
    input  logic [NCH-1:0]   inv_i,
    input  logic             buf_en_i,
    input  logic             per_wr_i,
    input  logic [CNT_W-1:0] per_data_i,
    input  logic [NCH-1:0]   cc_wr_i,
    input  logic [CNT_W-1:0] cc_data_i,
    input  logic             upd_cmd_i,
    input  logic             upd_lock_i,
    output logic [NCH-1:0]   wave_o,
    output logic [NCH-1:0]   match_o,
    output logic             reload_o,
    output logic [CNT_W-1:0] top_o
);
    wg_mode_e         mode;
    wg_size_e         size;
    logic             upd_req;
    logic             pwm;
    logic [CNT_W-1:0] per_act;
    logic             per_pend;
    logic [CNT_W-1:0] cc_act  [NCH];
    logic [NCH-1:0]   cc_pend;
    logic [CNT_W-1:0] mask;

    assign mode    = wg_mode_e'(mode_i);
    assign size    = wg_size_e'(size_i);
    assign upd_req = ovf_i || upd_cmd_i;
    assign pwm     = mode_i[1];

    wg_shadow #(.W(CNT_W)) u_per (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en_i), .wr(per_wr_i),
        .wdata(per_data_i), .upd_req(upd_req), .upd_lock(upd_lock_i),
        .act_o(per_act), .pend_o(per_pend)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        wg_shadow #(.W(CNT_W)) u_cc (
            .clk(clk), .rst_n(rst_n), .buf_en(buf_en_i), .wr(cc_wr_i[g]),
            .wdata(cc_data_i), .upd_req(upd_req), .upd_lock(upd_lock_i),
            .act_o(cc_act[g]), .pend_o(cc_pend[g])
        );
        wg_channel #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .count(count_i), .cc(cc_act[g]),
            .mask(mask), .pwm(pwm), .inv(inv_i[g]),
            .wave_o(wave_o[g]), .match_o(match_o[g])
        );
    end

    wg_topsel #(.CNT_W(CNT_W)) u_top (
        .mode(mode), .size(size), .per_act(per_act), .cc0_act(cc_act[0]),
        .count(count_i), .count_down(count_down_i),
        .mask_o(mask), .top_o(top_o), .reload_o(reload_o)
    );

    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (match_o == '0));
    assert_top_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (size == WG_SZ8) |-> (top_o <= CNT_W'(8'hFF)));
    assert_pend_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_lock_i && !per_wr_i && per_pend) |=> per_pend);
endmodule

// File: tb/wavegen_top_test.sv
`timescale 1ns/100ps
module wavegen_top_test;
    localparam int CNT_W = 32;
    localparam int NCH   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] count_i = '0;
    logic             count_down_i = 1'b0;
    logic             ovf_i = 1'b0;
    logic [1:0]       mode_i = 2'b10;
    logic [1:0]       size_i = 2'b01;
    logic [NCH-1:0]   inv_i = '0;
    logic             buf_en_i = 1'b0;
    logic             per_wr_i = 1'b0;
    logic [CNT_W-1:0] per_data_i = '0;
    logic [NCH-1:0]   cc_wr_i = '0;
    logic [CNT_W-1:0] cc_data_i = '0;
    logic             upd_cmd_i = 1'b0;
    logic             upd_lock_i = 1'b0;
    logic [NCH-1:0]   wave_o;
    logic [NCH-1:0]   match_o;
    logic             reload_o;
    logic [CNT_W-1:0] top_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wavegen_top #(.CNT_W(CNT_W), .NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .count_down_i(count_down_i),
        .ovf_i(ovf_i), .mode_i(mode_i), .size_i(size_i), .inv_i(inv_i),
        .buf_en_i(buf_en_i), .per_wr_i(per_wr_i), .per_data_i(per_data_i),
        .cc_wr_i(cc_wr_i), .cc_data_i(cc_data_i), .upd_cmd_i(upd_cmd_i),
        .upd_lock_i(upd_lock_i), .wave_o(wave_o), .match_o(match_o),
        .reload_o(reload_o), .top_o(top_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present a count at the falling edge; return 1 ns after the next rising edge.
    task automatic tick(input logic [CNT_W-1:0] c);
        @(negedge clk);
        count_i = c;
        @(posedge clk);
        #1;
    endtask

    task automatic wr_cc(input int ch, input logic [CNT_W-1:0] v);
        @(negedge clk);
        cc_wr_i[ch] = 1'b1;
        cc_data_i = v;
        @(posedge clk);
        #1 cc_wr_i = '0;
    endtask

    task automatic wr_per(input logic [CNT_W-1:0] v);
        @(negedge clk);
        per_wr_i = 1'b1;
        per_data_i = v;
        @(posedge clk);
        #1 per_wr_i = 1'b0;
    endtask

    task automatic pulse_upd(input logic lock, input logic use_ovf);
        @(negedge clk);
        upd_cmd_i  = !use_ovf;
        ovf_i      = use_ovf;
        upd_lock_i = lock;
        @(posedge clk);
        #1;
        upd_cmd_i = 1'b0;
        ovf_i = 1'b0;
        upd_lock_i = 1'b0;
    endtask

    task automatic t_reset();
        count_i = 32'd5;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 match in reset", 64'(match_o), 64'd0);
        chk("R11 wave in reset", 64'(wave_o), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_pwm();
        mode_i = 2'b10; size_i = 2'b01;
        wr_cc(0, 32'd3);
        tick(0); chk("R1 pwm set at restart", 64'(wave_o[0]), 64'd1);
        tick(1); chk("R1 pwm high before match", 64'(wave_o[0]), 64'd1);
        tick(2); chk("R3 no match at 2", 64'(match_o[0]), 64'd0);
        tick(3); chk("R1 pwm clear on match", 64'(wave_o[0]), 64'd0);
                 chk("R3 match flag at 3", 64'(match_o[0]), 64'd1);
        tick(4); chk("R3 match drops", 64'(match_o[0]), 64'd0);
                 chk("R1 pwm low after match", 64'(wave_o[0]), 64'd0);
    endtask

    task automatic t_invert();
        @(negedge clk); inv_i = 2'b01; #1;
        chk("R6 ch0 inverted", 64'(wave_o[0]), 64'd1);
        inv_i = 2'b10; #1;
        chk("R6 ch0 not inverted", 64'(wave_o[0]), 64'd0);
        chk("R6 ch1 inverted", 64'(wave_o[1]), 64'd1);
        inv_i = 2'b00;
    endtask

    task automatic t_freq();
        logic w;
        mode_i = 2'b00;
        wr_cc(1, 32'd2);
        tick(5); w = wave_o[1];
        tick(2); chk("R2 toggle on match", 64'(wave_o[1]), 64'(!w));
                 chk("R3 ch1 match", 64'(match_o[1]), 64'd1);
        tick(3); chk("R2 hold without match", 64'(wave_o[1]), 64'(!w));
        tick(2); chk("R2 toggle back", 64'(wave_o[1]), 64'(w));
    endtask

    task automatic t_top();
        mode_i = 2'b10; size_i = 2'b01;
        tick(32'hFFFF); chk("R4 top 16 normal", 64'(top_o), 64'hFFFF);
                        chk("R5 reload at max", 64'(reload_o), 64'd1);
        tick(32'hFFFE); chk("R5 no reload below top", 64'(reload_o), 64'd0);
        mode_i = 2'b11;
        tick(3);        chk("R4 top 16 match is cc0", 64'(top_o), 64'd3);
                        chk("R5 reload at cc0", 64'(reload_o), 64'd1);
        mode_i = 2'b10; size_i = 2'b10;
        tick(7);        chk("R4 top 32 normal", 64'(top_o), 64'hFFFF_FFFF);
        size_i = 2'b00;
        wr_per(32'd9);
        mode_i = 2'b11; #1;
        chk("R4 top 8 match is period", 64'(top_o), 64'd9);
        mode_i = 2'b00;
        tick(9);        chk("R4 top 8 normal is period", 64'(top_o), 64'd9);
                        chk("R5 reload at period", 64'(reload_o), 64'd1);
        count_down_i = 1'b1;
        tick(0);        chk("R5 down reload at zero", 64'(reload_o), 64'd1);
        tick(9);        chk("R5 down no reload at top", 64'(reload_o), 64'd0);
        count_down_i = 1'b0;
    endtask

    task automatic t_beyond_top();
        mode_i = 2'b10; size_i = 2'b00;
        wr_per(32'd5);
        wr_cc(1, 32'd10);
        for (int k = 0; k <= 5; k++) begin
            tick(32'(k));
            chk("R7 wave high past top", 64'(wave_o[1]), 64'd1);
            chk("R7 no match past top", 64'(match_o[1]), 64'd0);
        end
    endtask

    task automatic t_buffer();
        buf_en_i = 1'b1;
        wr_cc(1, 32'd2);
        tick(2); chk("R8 buffered write not active", 64'(match_o[1]), 64'd0);
        pulse_upd(1'b1, 1'b0);
        tick(2); chk("R9 locked update no commit", 64'(match_o[1]), 64'd0);
        pulse_upd(1'b0, 1'b0);
        tick(2); chk("R9 command commits", 64'(match_o[1]), 64'd1);
        wr_per(32'd7);
        #1 chk("R8 period buffered", 64'(top_o), 64'd5);
        pulse_upd(1'b0, 1'b1);
        chk("R9 overflow commits period", 64'(top_o), 64'd7);
        buf_en_i = 1'b0;
        wr_cc(1, 32'd4);
        tick(4); chk("R10 direct write active", 64'(match_o[1]), 64'd1);
    endtask

    initial begin
        t_reset();
        t_pwm();
        t_invert();
        t_freq();
        t_top();
        t_beyond_top();
        t_buffer();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule